// File: doc/BRIEF.md
# Security Alarm Response Controller

This block gathers the synchronised alarm lines of a secure controller's protection logic and turns them into one of two protective reactions. Environmental sensors (light, temperature, voltage glitch, clock frequency), the low-supply detector, the instruction fault detector and the stored-data integrity checkers (parity, ECC, complement or copy mismatch) each drive one bit of a single alarm vector. Each bit belongs to a class. The under-voltage and instruction-fault bits stop the processor. Every other bit asks for a whole-chip reset.

The chip reset request is stretched to a minimum width so that the reset generator always sees a clean pulse. The processor halt request follows its cause and has a short release tail. Each alarm bit also sets a sticky flag in a cause register. This block is reset only by power-on reset, so the flags survive the chip reset they trigger. Firmware reads them after restart and clears them with a clear strobe.

Top module: `sec_alarm_resp`

## Requirements
- R1: Alarm bit positions are fixed: 0 light, 1 temperature, 2 voltage glitch, 3 clock frequency, 4 low supply, 5 instruction fault, 6 parity error, 7 ECC error, 8 complement/copy mismatch. A bit sampled high at a clock edge sets the same bit of `cause_flags` from that edge on.
- R2: When bit 4 or bit 5 is sampled high, `halt_req` is high after that edge. This holds when no reset-class bit is high in the same cycle and `rst_req` is low.
- R3: When any of bits 0 to 3 is sampled high, `rst_req` is high after that edge.
- R4: `rst_req` stays high for exactly 16 cycles after the last cycle in which a reset-class bit was sampled. A new reset-class alarm during the pulse restarts the 16-cycle count.
- R5: `halt_req` stays high while a halt-class bit remains high. It falls exactly 2 cycles after the last cycle in which a halt-class bit was sampled.
- R6: Reset has priority over halt. A reset-class alarm that arrives together with a halt-class alarm, or while `halt_req` is high, drops `halt_req` at the same edge that raises `rst_req`. Halt-class alarms are ignored while `rst_req` is high, and `halt_req` is raised on the first edge after `rst_req` has fallen.
- R7: `cause_flags` keeps its bits across a `rst_req` pulse. A high `cause_clr` zeroes all bits at the next edge, except the bits whose alarm is sampled high in that same cycle.
- R8: While `por_n` is low, `halt_req`, `rst_req` and `cause_flags` are all zero. This reset acts immediately, without waiting for a clock edge.
- R9: Any of the integrity bits 6, 7 or 8 sampled high raises `rst_req` after that edge, in the same way as the sensor alarms.
- R10: `halt_req` and `rst_req` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| alarm_in | input | 9 | Synchronised alarm lines, bit map per R1 |
| cause_clr | input | 1 | Clear strobe for the cause register |
| halt_req | output | 1 | Processor halt request |
| rst_req | output | 1 | Chip reset request |
| cause_flags | output | 9 | Sticky alarm causes, bit map per R1 |

## Verification
The functions that can coincide are the halt reaction and the reset reaction. The bench provokes this in two ways: by raising the low-supply bit and a sensor bit in the same cycle, and by raising an integrity bit while the halt is already active. Each time it requires that the edge raising `rst_req` leaves `halt_req` low. The bench then holds the halt cause through the whole reset pulse and confirms that `halt_req` stays low until exactly one edge after `rst_req` has fallen. A second collision, a cause-register clear together with a new alarm, is judged by reading back only the newly set bit.

// File: rtl/sec_alarm_pkg.sv
package sec_alarm_pkg;
   localparam int unsigned SRC_N = 9;

   localparam int unsigned SRC_LIGHT  = 0;
   localparam int unsigned SRC_TEMP   = 1;
   localparam int unsigned SRC_GLITCH = 2;
   localparam int unsigned SRC_FREQ   = 3;
   localparam int unsigned SRC_LOWV   = 4;
   localparam int unsigned SRC_INSN   = 5;
   localparam int unsigned SRC_PAR    = 6;
   localparam int unsigned SRC_ECC    = 7;
   localparam int unsigned SRC_CMP    = 8;

   typedef logic [SRC_N-1:0] src_vec_t;

   // Sources whose reaction is a processor halt; all others reset the chip.
   localparam src_vec_t HALT_CLASS_DEF = src_vec_t'((1 << SRC_LOWV) | (1 << SRC_INSN));

   localparam int unsigned RST_HOLD_DEF  = 16;
   localparam int unsigned HALT_TAIL_DEF = 2;
endpackage

// File: rtl/sec_alarm_classify.sv
module sec_alarm_classify #(
   parameter int unsigned         NUM_SRC   = sec_alarm_pkg::SRC_N,
   parameter logic [NUM_SRC-1:0]  HALT_MASK = sec_alarm_pkg::HALT_CLASS_DEF
) (
   input  logic [NUM_SRC-1:0] alarm,
   output logic               halt_cause,
   output logic               rst_cause
);
   logic [NUM_SRC-1:0] halt_bits;
   logic [NUM_SRC-1:0] rst_bits;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      if (HALT_MASK[i]) begin : g_halt
         assign halt_bits[i] = alarm[i];
         assign rst_bits[i]  = 1'b0;
      end else begin : g_rst
         assign halt_bits[i] = 1'b0;
         assign rst_bits[i]  = alarm[i];
      end
   end

   assign halt_cause = |halt_bits;
   assign rst_cause  = |rst_bits;
endmodule

// File: rtl/sec_hold_timer.sv
module sec_hold_timer #(
   parameter int unsigned CNT_MAX = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic kill,
   output logic active
);
   if (CNT_MAX < 1) begin : g_bad
      $error("sec_hold_timer: CNT_MAX must be at least 1");
   end

   if (CNT_MAX == 1) begin : g_flop
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    q <= 1'b0;
         else if (kill) q <= 1'b0;
         else           q <= load;
      end
      assign active = q;
   end else begin : g_cnt
      localparam int unsigned CW = $clog2(CNT_MAX + 1);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              cnt_q <= '0;
         else if (kill)           cnt_q <= '0;
         else if (load)           cnt_q <= CW'(CNT_MAX);
         else if (cnt_q != '0)    cnt_q <= cnt_q - CW'(1);
      end
      assign active = (cnt_q != '0);
   end
endmodule

// File: rtl/sec_cause_latch.sv
module sec_cause_latch #(
   parameter int unsigned NUM_SRC = sec_alarm_pkg::SRC_N
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic [NUM_SRC-1:0] set,
   output logic [NUM_SRC-1:0] flags
);
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
      logic f_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) f_q <= 1'b0;
         else        f_q <= (f_q & ~clr) | set[i];
      end
      assign flags[i] = f_q;
   end
endmodule

// File: rtl/sec_alarm_resp.sv
module sec_alarm_resp #(
   parameter int unsigned        NUM_SRC   = sec_alarm_pkg::SRC_N,
   parameter logic [NUM_SRC-1:0] HALT_MASK = sec_alarm_pkg::HALT_CLASS_DEF,
   parameter int unsigned        RST_HOLD  = sec_alarm_pkg::RST_HOLD_DEF,
   parameter int unsigned        HALT_TAIL = sec_alarm_pkg::HALT_TAIL_DEF
) (
   input  logic               clk,
   input  logic               por_n,
   input  logic [NUM_SRC-1:0] alarm_in,
   input  logic               cause_clr,
   output logic               halt_req,
   output logic               rst_req,
   output logic [NUM_SRC-1:0] cause_flags
);
   if (NUM_SRC < 2) begin : g_chk_src
      $error("sec_alarm_resp: NUM_SRC must be at least 2");
   end
   if (RST_HOLD < 16) begin : g_chk_hold
      $error("sec_alarm_resp: RST_HOLD below the minimum reset width of 16");
   end
   if (HALT_TAIL < 1) begin : g_chk_tail
      $error("sec_alarm_resp: HALT_TAIL must be at least 1");
   end
   if (&HALT_MASK) begin : g_chk_mask
      $error("sec_alarm_resp: at least one source must be reset-class");
   end

   logic halt_cause;
   logic rst_cause;
   logic halt_load;
   logic halt_kill;

   sec_alarm_classify #(
      .NUM_SRC   (NUM_SRC),
      .HALT_MASK (HALT_MASK)
   ) u_class (
      .alarm      (alarm_in),
      .halt_cause (halt_cause),
      .rst_cause  (rst_cause)
   );

   sec_hold_timer #(
      .CNT_MAX (RST_HOLD)
   ) u_rst_tmr (
      .clk    (clk),
      .rst_n  (por_n),
      .load   (rst_cause),
      .kill   (1'b0),
      .active (rst_req)
   );

   // Reset wins: a pending or active reset clears and blocks the halt.
   assign halt_kill = rst_cause | rst_req;
   assign halt_load = halt_cause & ~halt_kill;

   sec_hold_timer #(
      .CNT_MAX (HALT_TAIL)
   ) u_halt_tmr (
      .clk    (clk),
      .rst_n  (por_n),
      .load   (halt_load),
      .kill   (halt_kill),
      .active (halt_req)
   );

   sec_cause_latch #(
      .NUM_SRC (NUM_SRC)
   ) u_cause (
      .clk   (clk),
      .rst_n (por_n),
      .clr   (cause_clr),
      .set   (alarm_in),
      .flags (cause_flags)
   );
endmodule

// File: rtl/sec_alarm_resp_chk.sv
module sec_alarm_resp_chk #(
   parameter int unsigned        NUM_SRC   = sec_alarm_pkg::SRC_N,
   parameter logic [NUM_SRC-1:0] HALT_MASK = sec_alarm_pkg::HALT_CLASS_DEF,
   parameter int unsigned        RST_HOLD  = sec_alarm_pkg::RST_HOLD_DEF
) (
   input logic               clk,
   input logic               por_n,
   input logic [NUM_SRC-1:0] alarm_in,
   input logic               cause_clr,
   input logic               halt_req,
   input logic               rst_req,
   input logic [NUM_SRC-1:0] cause_flags
);
   localparam int unsigned RW = $clog2(RST_HOLD + 2) + 1;
   localparam logic [RW-1:0] RUN_MAX = '1;

   logic          hc;
   logic          rc;
   logic [RW-1:0] run_q;

   assign hc = |(alarm_in & HALT_MASK);
   assign rc = |(alarm_in & ~HALT_MASK);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)             run_q <= '0;
      else if (!rst_req)      run_q <= '0;
      else if (run_q != RUN_MAX) run_q <= run_q + RW'(1);
   end

   p_excl_r10: assert property (@(posedge clk) disable iff (!por_n)
      !(halt_req && rst_req));

   p_rst_start_r3: assert property (@(posedge clk) disable iff (!por_n)
      rc |=> rst_req);

   p_halt_start_r2: assert property (@(posedge clk) disable iff (!por_n)
      (hc && !rc && !rst_req) |=> halt_req);

   p_rst_width_r4: assert property (@(posedge clk) disable iff (!por_n)
      $fell(rst_req) |-> (run_q >= RW'(RST_HOLD)));

   p_cause_set_r1: assert property (@(posedge clk) disable iff (!por_n)
      (alarm_in != '0) |=> ((cause_flags & $past(alarm_in)) == $past(alarm_in)));

   p_cause_keep_r7: assert property (@(posedge clk) disable iff (!por_n)
      !cause_clr |=> ((cause_flags & $past(cause_flags)) == $past(cause_flags)));

   p_rst_prio_r6: assert property (@(posedge clk) disable iff (!por_n)
      rc |=> !halt_req);
endmodule

bind sec_alarm_resp sec_alarm_resp_chk #(
   .NUM_SRC   (NUM_SRC),
   .HALT_MASK (HALT_MASK),
   .RST_HOLD  (RST_HOLD)
) u_chk (
   .clk         (clk),
   .por_n       (por_n),
   .alarm_in    (alarm_in),
   .cause_clr   (cause_clr),
   .halt_req    (halt_req),
   .rst_req     (rst_req),
   .cause_flags (cause_flags)
);

// File: tb/sec_alarm_resp_tb_top.sv
module sec_alarm_resp_tb_top;
   localparam int unsigned N = 9;

   logic         clk = 1'b0;
   logic         por_n;
   logic [N-1:0] alarm_in;
   logic         cause_clr;
   logic         halt_req;
   logic         rst_req;
   logic [N-1:0] cause_flags;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   always #10 clk = ~clk;

   sec_alarm_resp dut_i (
      .clk         (clk),
      .por_n       (por_n),
      .alarm_in    (alarm_in),
      .cause_clr   (cause_clr),
      .halt_req    (halt_req),
      .rst_req     (rst_req),
      .cause_flags (cause_flags)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic clear_causes();
      cause_clr = 1'b1;
      step();
      cause_clr = 1'b0;
      check("R7 clear", 32'(cause_flags), 32'h0);
   endtask

   task automatic t_reset_state();
      check("R8 halt at reset", 32'(halt_req), 0);
      check("R8 rst at reset", 32'(rst_req), 0);
      check("R8 cause at reset", 32'(cause_flags), 0);
   endtask

   task automatic t_lowv_halt();
      alarm_in = N'(1 << 4);
      step();
      check("R2 lowv halt", 32'(halt_req), 1);
      check("R10 no rst on lowv", 32'(rst_req), 0);
      check("R1 lowv cause bit", 32'(cause_flags), 32'h10);
      repeat (3) step();
      check("R5 halt while present", 32'(halt_req), 1);
      alarm_in = '0;
      step();
      check("R5 tail cycle 1", 32'(halt_req), 1);
      step();
      check("R5 released after 2", 32'(halt_req), 0);
      check("R7 cause kept", 32'(cause_flags), 32'h10);
      clear_causes();
   endtask

   task automatic t_insn_pulse();
      alarm_in = N'(1 << 5);
      step();
      alarm_in = '0;
      check("R2 insn halt", 32'(halt_req), 1);
      step();
      check("R5 insn tail", 32'(halt_req), 1);
      step();
      check("R5 insn release", 32'(halt_req), 0);
      check("R1 insn cause bit", 32'(cause_flags), 32'h20);
      clear_causes();
   endtask

   task automatic t_reset_src(input int idx, input string req);
      int n;
      bit bad_halt;
      alarm_in = N'(1 << idx);
      step();
      alarm_in = '0;
      check(req, 32'(rst_req), 1);
      n = 1;
      bad_halt = halt_req;
      while (rst_req && n < 100) begin
         step();
         if (rst_req) n++;
         if (halt_req && rst_req) bad_halt = 1;
      end
      check("R4 reset width 16", 32'(n), 16);
      check("R10 exclusive", 32'(bad_halt), 0);
      check("R7 cause survives reset", 32'(cause_flags), 32'(1 << idx));
      clear_causes();
   endtask

   task automatic t_extend();
      int n;
      alarm_in = N'(1 << 1);
      step();
      alarm_in = '0;
      n = 1;
      repeat (4) begin step(); n++; end
      alarm_in = N'(1 << 1);
      step();
      alarm_in = '0;
      n++;
      while (rst_req && n < 100) begin
         step();
         if (rst_req) n++;
      end
      check("R4 retrigger width", 32'(n), 21);
      clear_causes();
   endtask

   task automatic t_same_cycle();
      int guard;
      bit bad;
      alarm_in = N'((1 << 4) | (1 << 0));
      step();
      alarm_in = N'(1 << 4);
      check("R6 reset wins rst", 32'(rst_req), 1);
      check("R6 reset wins halt", 32'(halt_req), 0);
      check("R1 both causes", 32'(cause_flags), 32'h11);
      guard = 0;
      bad = 0;
      while (rst_req && guard < 100) begin
         step();
         guard++;
         if (halt_req) bad = 1;
      end
      check("R6 halt ignored during reset", 32'(bad), 0);
      step();
      check("R6 halt after reset", 32'(halt_req), 1);
      alarm_in = '0;
      repeat (3) step();
      clear_causes();
   endtask

   task automatic t_rst_during_halt();
      int guard;
      alarm_in = N'(1 << 4);
      step();
      check("R2 halt before reset", 32'(halt_req), 1);
      alarm_in = N'((1 << 4) | (1 << 8));
      step();
      alarm_in = '0;
      check("R9 cmp reset", 32'(rst_req), 1);
      check("R6 halt dropped", 32'(halt_req), 0);
      guard = 0;
      while (rst_req && guard < 100) begin step(); guard++; end
      check("R6 no halt after reset", 32'(halt_req), 0);
      clear_causes();
   endtask

   task automatic t_clr_collide();
      alarm_in = N'(1 << 5);
      step();
      alarm_in = '0;
      repeat (3) step();
      alarm_in  = N'(1 << 3);
      step();
      alarm_in  = '0;
      repeat (20) step();
      check("R7 two causes", 32'(cause_flags), 32'h28);
      cause_clr = 1'b1;
      alarm_in  = N'(1 << 5);
      step();
      cause_clr = 1'b0;
      alarm_in  = '0;
      check("R7 clear vs new", 32'(cause_flags), 32'h20);
      repeat (3) step();
      clear_causes();
   endtask

   task automatic t_por_mid();
      alarm_in = N'(1 << 2);
      step();
      alarm_in = '0;
      check("R3 glitch reset", 32'(rst_req), 1);
      por_n = 1'b0;
      #1;
      check("R8 async rst", 32'(rst_req), 0);
      check("R8 async cause", 32'(cause_flags), 0);
      step();
      por_n = 1'b1;
      step();
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      por_n     = 1'b0;
      alarm_in  = '0;
      cause_clr = 1'b0;
      repeat (3) @(negedge clk);
      t_reset_state();
      por_n = 1'b1;
      step();
      t_lowv_halt();
      t_insn_pulse();
      t_reset_src(0, "R3 light");
      t_reset_src(1, "R3 temp");
      t_reset_src(2, "R3 glitch");
      t_reset_src(3, "R3 freq");
      t_reset_src(6, "R9 parity");
      t_reset_src(7, "R9 ecc");
      t_reset_src(8, "R9 cmp");
      t_extend();
      t_same_cycle();
      t_rst_during_halt();
      t_clr_collide();
      t_por_mid();
      finish_run();
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end
endmodule